// File: doc/BRIEF.md
# Keyed Operating-Mode Request Register

This block holds the software-visible registers that decide which operating mode the device should move to next. Software names a target mode through a control register. A change is accepted only after two supervisor writes in order: the first carries the forward key and the second carries the inverted key, and both name the same mode. A companion enable register selects which modes may be requested. Four modes are always enabled.

When a sequence completes and names a legal, enabled mode, the block raises a one-cycle request that carries the target code to the mode state machine next to it. A sequence that names an illegal or disabled mode sets a sticky error flag and does nothing else. Hardware can also update the target field without software. A safe-state request loads SAFE. A wake-up event that arrives while the device is in a low-power mode loads the RUN mode selected by the wake logic. Both hardware events also raise the request pulse.

Top module: `mode_ctl`

## Requirements
- R1: After reset, a control read returns 0x3000A50F (target DRUN = 4'b0011 in bits 31:28, bits 27:16 zero, key field 0xA50F in bits 15:0). An enable read returns 0x001D, and modeReq and invalidMode are 0.
- R2: Mode codes are RESET 0, TEST 1, SAFE 2, DRUN 3, RUN0..RUN3 4..7, HALT0 8 and STOP0 10. The target is bits 31:28 of the control word and the key is bits 15:0. A supervisor control write with key 0x5AF0, followed by a supervisor control write with key 0xA50F naming the same legal, enabled mode, loads the target field. It also pulses modeReq for exactly one cycle, with modeReqTarget equal to that mode, in the cycle after the second write.
- R3: Every control-register read returns 0xA50F in bits 15:0 and zero in bits 27:16.
- R4: A control write whose key is neither 0x5AF0 nor 0xA50F is ignored. It changes no register and does not cancel a pending first step.
- R5: An inverted-key write that has no pending first step, or whose target differs from the first step, is discarded. It issues no request, leaves the target unchanged and clears the pending step.
- R6: A completed sequence that names a reserved code (9, 11..15) or a mode whose enable bit is 0 sets invalidMode. invalidMode then stays set until reset. No request is issued and the target is unchanged.
- R7: In the enable register, bit n enables mode code n. Only bits 0..8 and 10 are implemented, and the others read 0. Bits 0, 2, 3 and 4 (RESET, SAFE, DRUN, RUN0) always read 1.
- R8: Writes with busSuper low are ignored for both registers. Reads with busSuper low return normal data.
- R9: hwSafeReq loads SAFE into the target field and pulses modeReq with SAFE in the next cycle. It takes priority over a completing software sequence in the same cycle and cancels any pending first step.
- R10: wakeEvent while curMode is HALT0 or STOP0 loads RUN0+resumeRun into the target and pulses modeReq with that code, unless hwSafeReq is also high. In any other current mode wakeEvent has no effect.
- R11: busRdata is registered: it shows the addressed register in the cycle after busRead. Address 0 is the control register, address 1 is the enable register, and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register word address |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busSuper | input | 1 | Supervisor or test access |
| busRdata | output | 32 | Registered read data |
| hwSafeReq | input | 1 | Hardware request to enter SAFE |
| wakeEvent | input | 1 | Wake-up event from a low-power mode |
| resumeRun | input | 2 | RUN mode index to resume into on wake |
| curMode | input | 4 | Current device mode code |
| modeReq | output | 1 | One-cycle mode-change request |
| modeReqTarget | output | 4 | Mode code carried with the request |
| invalidMode | output | 1 | Sticky flag for an illegal or disabled request |

## Verification
The properties assume that busWrite and busRead are never high in the same cycle, and that the hardware event inputs are one-cycle pulses sampled at the clock edge. They also assume that curMode holds a defined mode code. The stimulus drives each bus access for exactly one clock, raises hwSafeReq and wakeEvent for one cycle only, and never overlaps a read with a write. Same-cycle collisions between a hardware event and a completing write are produced on purpose, with both held for the same single cycle.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  localparam int DATA_W = 32;
  localparam int MODE_W = 4;
  localparam int KEY_W  = 16;
  localparam int EN_W   = 16;

  localparam logic [MODE_W-1:0] MD_RESET = 4'd0;
  localparam logic [MODE_W-1:0] MD_SAFE  = 4'd2;
  localparam logic [MODE_W-1:0] MD_DRUN  = 4'd3;
  localparam logic [MODE_W-1:0] MD_RUN0  = 4'd4;
  localparam logic [MODE_W-1:0] MD_HALT0 = 4'd8;
  localparam logic [MODE_W-1:0] MD_STOP0 = 4'd10;

  localparam logic [KEY_W-1:0] KEY_FWD = 16'h5AF0;
  localparam logic [KEY_W-1:0] KEY_INV = 16'hA50F;

  localparam logic [EN_W-1:0] EN_IMPL   = 16'h05FF;
  localparam logic [EN_W-1:0] EN_FORCED = 16'h001D;

  typedef enum logic [1:0] {RD_CTRL = 2'd0, RD_EN = 2'd1, RD_NONE = 2'd2} rdSelE;

  typedef struct packed {
    logic              loadTgt;
    logic [MODE_W-1:0] newTgt;
    logic              fireReq;
    logic              flagInvalid;
    logic              wrEnable;
    logic [EN_W-1:0]   enData;
    logic              rdStrobe;
    rdSelE             rdSel;
  } strobeT;

  function automatic logic isLowPower(input logic [MODE_W-1:0] m);
    return (m == MD_HALT0) || (m == MD_STOP0);
  endfunction

  function automatic logic isKnownMode(input logic [MODE_W-1:0] m);
    return (m <= MD_HALT0) || (m == MD_STOP0);
  endfunction
endpackage

// File: rtl/mode_ctl_ctrl.sv
module mode_ctl_ctrl
  import mode_ctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busSuper,
  input  logic              hwSafeReq,
  input  logic              wakeEvent,
  input  logic [1:0]        resumeRun,
  input  logic [MODE_W-1:0] curMode,
  input  logic [EN_W-1:0]   enableVal,
  output strobeT            strb
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(1);

  logic              armed;
  logic [MODE_W-1:0] pendTgt;
  logic              ctlWr;
  logic              keyFwd;
  logic              keyInv;
  logic              complete;
  logic              hwWake;
  logic [MODE_W-1:0] wrTgt;
  logic              unusedBits;

  assign wrTgt      = busWdata[DATA_W-1 -: MODE_W];
  assign unusedBits = ^busWdata[DATA_W-MODE_W-1:KEY_W];
  assign ctlWr      = busWrite && busSuper && (busAddr == CTRL_ADDR);
  assign keyFwd     = busWdata[KEY_W-1:0] == KEY_FWD;
  assign keyInv     = busWdata[KEY_W-1:0] == KEY_INV;
  assign complete   = ctlWr && keyInv && armed && (wrTgt == pendTgt);
  assign hwWake     = wakeEvent && isLowPower(curMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      pendTgt <= '0;
    end else if (hwSafeReq || hwWake) begin
      armed <= 1'b0;
    end else if (ctlWr && keyFwd) begin
      armed   <= 1'b1;
      pendTgt <= wrTgt;
    end else if (ctlWr && keyInv) begin
      armed <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = RD_NONE;
    if (hwSafeReq) begin
      strb.loadTgt = 1'b1;
      strb.newTgt  = MD_SAFE;
      strb.fireReq = 1'b1;
    end else if (hwWake) begin
      strb.loadTgt = 1'b1;
      strb.newTgt  = MD_RUN0 + {2'b00, resumeRun};
      strb.fireReq = 1'b1;
    end else if (complete) begin
      if (isKnownMode(wrTgt) && enableVal[wrTgt]) begin
        strb.loadTgt = 1'b1;
        strb.newTgt  = wrTgt;
        strb.fireReq = 1'b1;
      end else begin
        strb.flagInvalid = 1'b1;
      end
    end
    strb.wrEnable = busWrite && busSuper && (busAddr == EN_ADDR);
    strb.enData   = busWdata[EN_W-1:0];
    strb.rdStrobe = busRead;
    if (busAddr == CTRL_ADDR)     strb.rdSel = RD_CTRL;
    else if (busAddr == EN_ADDR)  strb.rdSel = RD_EN;
  end
endmodule

// File: rtl/mode_ctl_dp.sv
module mode_ctl_dp
  import mode_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  output logic [MODE_W-1:0] targetVal,
  output logic [EN_W-1:0]   enableVal,
  output logic [DATA_W-1:0] busRdata,
  output logic              modeReq,
  output logic [MODE_W-1:0] modeReqTarget,
  output logic              invalidMode
);
  localparam int PAD_W = DATA_W - MODE_W - KEY_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetVal     <= MD_DRUN;
      enableVal     <= EN_FORCED;
      modeReq       <= 1'b0;
      modeReqTarget <= MD_RESET;
      invalidMode   <= 1'b0;
      busRdata      <= '0;
    end else begin
      modeReq <= strb.fireReq;
      if (strb.fireReq) modeReqTarget <= strb.newTgt;
      if (strb.loadTgt) targetVal <= strb.newTgt;
      if (strb.flagInvalid) invalidMode <= 1'b1;
      if (strb.wrEnable) enableVal <= (strb.enData & EN_IMPL) | EN_FORCED;
      if (strb.rdStrobe) begin
        case (strb.rdSel)
          RD_CTRL: busRdata <= {targetVal, {PAD_W{1'b0}}, KEY_INV};
          RD_EN:   busRdata <= {{(DATA_W-EN_W){1'b0}}, enableVal};
          default: busRdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
  import mode_ctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [31:0]       busWdata,
  input  logic              busSuper,
  output logic [31:0]       busRdata,
  input  logic              hwSafeReq,
  input  logic              wakeEvent,
  input  logic [1:0]        resumeRun,
  input  logic [3:0]        curMode,
  output logic              modeReq,
  output logic [3:0]        modeReqTarget,
  output logic              invalidMode
);
  strobeT            strb;
  logic [MODE_W-1:0] targetVal;
  logic [EN_W-1:0]   enableVal;

  mode_ctl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busSuper(busSuper),
    .hwSafeReq(hwSafeReq), .wakeEvent(wakeEvent), .resumeRun(resumeRun),
    .curMode(curMode), .enableVal(enableVal), .strb(strb)
  );

  mode_ctl_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .targetVal(targetVal),
    .enableVal(enableVal), .busRdata(busRdata), .modeReq(modeReq),
    .modeReqTarget(modeReqTarget), .invalidMode(invalidMode)
  );
endmodule

// File: rtl/mode_ctl_sva.sv
module mode_ctl_sva #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              busRead,
  input logic              busSuper,
  input logic [31:0]       busRdata,
  input logic              hwSafeReq,
  input logic              wakeEvent,
  input logic              modeReq,
  input logic [3:0]        modeReqTarget,
  input logic              invalidMode,
  input logic [3:0]        targetVal,
  input logic [15:0]       enableVal
);
  assert_locked_enables_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enableVal & 16'h001D) == 16'h001D);

  assert_unimpl_enables_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enableVal & 16'hFA00) == 16'h0000);

  assert_invalid_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    invalidMode |=> invalidMode);

  assert_req_code_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeReq |-> (modeReqTarget != 4'd9 && modeReqTarget < 4'd11));

  assert_safe_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    hwSafeReq |=> (modeReq && modeReqTarget == 4'd2 && targetVal == 4'd2));

  assert_user_write_inert_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !busSuper && !hwSafeReq && !wakeEvent)
      |=> ($stable(enableVal) && $stable(targetVal) && !modeReq));

  assert_key_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == '0) |=> (busRdata[15:0] == 16'hA50F && busRdata[27:16] == 12'h0));
endmodule

bind mode_ctl mode_ctl_sva #(.ADDR_W(ADDR_W)) uSva (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busRead(busRead), .busSuper(busSuper), .busRdata(busRdata),
  .hwSafeReq(hwSafeReq), .wakeEvent(wakeEvent), .modeReq(modeReq),
  .modeReqTarget(modeReqTarget), .invalidMode(invalidMode),
  .targetVal(targetVal), .enableVal(enableVal)
);

// File: tb/mode_ctl_test.sv
module mode_ctl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busSuper = 1'b1;
  logic [31:0] busRdata;
  logic        hwSafeReq = 1'b0;
  logic        wakeEvent = 1'b0;
  logic [1:0]  resumeRun = '0;
  logic [3:0]  curMode = 4'd3;
  logic        modeReq;
  logic [3:0]  modeReqTarget;
  logic        invalidMode;

  int checks = 0;
  int fails = 0;
  logic [3:0] expQ[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  mode_ctl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busSuper(busSuper),
    .busRdata(busRdata), .hwSafeReq(hwSafeReq), .wakeEvent(wakeEvent),
    .resumeRun(resumeRun), .curMode(curMode), .modeReq(modeReq),
    .modeReqTarget(modeReqTarget), .invalidMode(invalidMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every request pulse is popped from the scoreboard
  always @(negedge clk) begin
    if (rstN && !done && modeReq) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected request actual=%h expected=none", modeReqTarget);
      end else begin
        logic [3:0] e;
        e = expQ.pop_front();
        if (modeReqTarget !== e) begin
          fails++;
          $display("FAIL R2 request target actual=%h expected=%h", modeReqTarget, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic sup);
    @(negedge clk);
    busAddr = a; busWdata = d; busSuper = sup; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busSuper = 1'b1;
  endtask

  function automatic logic [31:0] cw(input logic [3:0] m, input logic [15:0] k);
    return {m, 12'h0, k};
  endfunction

  task automatic rdChk(input string req, input logic [1:0] a, input logic sup,
                       input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busSuper = sup; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0; busSuper = 1'b1;
    chk(req, busRdata, exp);
  endtask

  task automatic seq(input logic [3:0] m, input bit expectReq);
    if (expectReq) expQ.push_back(m);
    wr(2'd0, cw(m, 16'h5AF0), 1'b1);
    wr(2'd0, cw(m, 16'hA50F), 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 modeReq", {31'h0, modeReq}, 32'h0);
    chk("R1 invalidMode", {31'h0, invalidMode}, 32'h0);
    rdChk("R1 R11 control reset", 2'd0, 1'b1, 32'h3000A50F);
    rdChk("R1 R11 enable reset", 2'd1, 1'b1, 32'h0000001D);
    rdChk("R11 unmapped", 2'd2, 1'b1, 32'h0);

    // R2 valid sequence to RUN0
    seq(4'd4, 1'b1);
    rdChk("R2 target RUN0", 2'd0, 1'b1, 32'h4000A50F);

    // R4 wrong key between steps does not cancel
    expQ.push_back(4'd2);
    wr(2'd0, cw(4'd2, 16'h5AF0), 1'b1);
    wr(2'd0, cw(4'd7, 16'h1234), 1'b1);
    rdChk("R4 ignored write", 2'd0, 1'b1, 32'h4000A50F);
    wr(2'd0, cw(4'd2, 16'hA50F), 1'b1);
    rdChk("R4 R2 target SAFE", 2'd0, 1'b1, 32'h2000A50F);

    // R5 mismatched target, then lone inverted
    wr(2'd0, cw(4'd4, 16'h5AF0), 1'b1);
    wr(2'd0, cw(4'd3, 16'hA50F), 1'b1);
    wr(2'd0, cw(4'd3, 16'hA50F), 1'b1);
    rdChk("R5 discarded", 2'd0, 1'b1, 32'h2000A50F);

    // R8 user writes ignored, user read allowed
    wr(2'd0, cw(4'd3, 16'h5AF0), 1'b0);
    wr(2'd0, cw(4'd3, 16'hA50F), 1'b0);
    wr(2'd1, 32'h0000FFFF, 1'b0);
    rdChk("R8 user ctrl read", 2'd0, 1'b0, 32'h2000A50F);
    rdChk("R8 user enable read", 2'd1, 1'b0, 32'h0000001D);

    // R6 disabled mode RUN1
    seq(4'd5, 1'b0);
    @(negedge clk);
    chk("R6 invalid disabled", {31'h0, invalidMode}, 32'h1);
    rdChk("R6 target kept", 2'd0, 1'b1, 32'h2000A50F);

    // R7 enable register
    wr(2'd1, 32'h00000000, 1'b1);
    rdChk("R7 forced bits", 2'd1, 1'b1, 32'h0000001D);
    wr(2'd1, 32'hFFFFFFFF, 1'b1);
    rdChk("R7 implemented bits", 2'd1, 1'b1, 32'h000005FF);
    seq(4'd5, 1'b1);
    rdChk("R7 R2 RUN1 now enabled", 2'd0, 1'b1, 32'h5000A50F);
    // reserved code still invalid, sticky flag stays
    seq(4'd9, 1'b0);
    rdChk("R6 reserved target kept", 2'd0, 1'b1, 32'h5000A50F);
    chk("R6 sticky", {31'h0, invalidMode}, 32'h1);
    seq(4'd10, 1'b1);
    rdChk("R2 STOP0", 2'd0, 1'b1, 32'hA000A50F);

    // R9 safe beats completion and cancels arming
    wr(2'd0, cw(4'd6, 16'h5AF0), 1'b1);
    expQ.push_back(4'd2);
    @(negedge clk);
    busAddr = 2'd0; busWdata = cw(4'd6, 16'hA50F); busWrite = 1'b1; hwSafeReq = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; hwSafeReq = 1'b0;
    rdChk("R9 safe loaded", 2'd0, 1'b1, 32'h2000A50F);
    wr(2'd0, cw(4'd6, 16'h5AF0), 1'b1);
    expQ.push_back(4'd2);
    @(negedge clk); hwSafeReq = 1'b1;
    @(negedge clk); hwSafeReq = 1'b0;
    wr(2'd0, cw(4'd6, 16'hA50F), 1'b1);
    rdChk("R9 arming cancelled", 2'd0, 1'b1, 32'h2000A50F);

    // R10 wake from HALT0 and STOP0, ignored otherwise
    curMode = 4'd8; resumeRun = 2'd2;
    expQ.push_back(4'd6);
    @(negedge clk); wakeEvent = 1'b1;
    @(negedge clk); wakeEvent = 1'b0;
    rdChk("R10 wake HALT0", 2'd0, 1'b1, 32'h6000A50F);
    curMode = 4'd10; resumeRun = 2'd3;
    expQ.push_back(4'd7);
    @(negedge clk); wakeEvent = 1'b1;
    @(negedge clk); wakeEvent = 1'b0;
    rdChk("R10 wake STOP0", 2'd0, 1'b1, 32'h7000A50F);
    curMode = 4'd4; resumeRun = 2'd0;
    @(negedge clk); wakeEvent = 1'b1;
    @(negedge clk); wakeEvent = 1'b0;
    rdChk("R10 wake ignored", 2'd0, 1'b1, 32'h7000A50F);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", expQ.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule